// File: doc/BRIEF.md
# Display Power Sequencer

This block brings the three power domains of a display pipeline up and down in a fixed order. The domains are the pixel clock, the sync generator and the display data path. Software requests a domain through a write-one-to-set command register and releases it through a write-one-to-clear command register. A per-domain timer models the domain's settling time. A status register reports a domain as running only once that time has elapsed. Commands that would break the order are dropped, so the pipeline never runs a stage whose feeder stage is off.

The same register port also holds a one-bit start-of-frame interrupt mask, which has its own set and clear registers. A start-of-frame pulse from the timing generator latches a pending flag. The interrupt line is high while that flag and the mask are both set, and reading the status register acknowledges the flag. The block is driven by a simple single-cycle register port: one address, a write strobe, a read strobe and a read result one cycle later.

Top module: `disp_pwr_seq`

## Requirements
- R1: Domain bits share positions across the command and status registers: bit 0 is the pixel clock, bit 1 is sync and bit 2 is display. A write to address 0 requests each domain whose bit is 1. The request shows on `domainReq` in the cycle after the write.
- R2: A write of zero bits to address 0, address 1 or the interrupt registers changes neither requests, status nor mask.
- R3: A domain's `domainUp` bit takes its requested value exactly SETTLE clock cycles after the write edge of the last accepted command for that domain. It does not change at any other time.
- R4: An enable for sync is dropped unless the pixel clock is both running and still requested. An enable for display is dropped unless sync is both running and still requested. An enable for the pixel clock is always accepted.
- R5: A write to address 1 releases each domain whose bit is 1. A release of the pixel clock is dropped while sync is running or requested. A release of sync is dropped while display is running or requested. A release of display is always accepted.
- R6: A release accepted while that domain's enable is still settling cancels it. The domain's status bit never rises.
- R7: Reading address 2 returns the running bits in [2:0] and the start-of-frame pending flag in bit 3. The read clears the flag, unless a start-of-frame pulse arrives in the same cycle, in which case the flag stays set.
- R8: Writing bit 0 = 1 to address 3 sets the interrupt mask. Writing bit 0 = 1 to address 4 clears it. Address 5 reads the mask in bit 0.
- R9: `irqOut` is high exactly while the pending flag and the mask are both set.
- R10: Under reset, all requests, status bits, the mask, the pending flag and `irqOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid the cycle after `regRd` |
| sofPulse | input | 1 | Start-of-frame event, one cycle |
| irqOut | output | 1 | Start-of-frame interrupt |
| domainReq | output | 3 | Requested state per domain |
| domainUp | output | 3 | Settled running state per domain |

## Verification
The sequencing function is driven with ordered power-up and power-down runs, and with every out-of-order command. These separate the enable-side prerequisite check from the release-side check. Zero-valued writes separate a write-one decode from a plain register load. A single-cycle timing probe either side of the settling edge distinguishes an off-by-one timer. Two further cases cover a release during enable settling and an enable during a lower stage's release, and they tell "running" apart from "running and still requested". A start-of-frame pulse arriving together with a status read tests the priority of set over acknowledge.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int NDOM   = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_EN    = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIS   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IDIS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IMASK = 3'd5;

  localparam int BIT_SOF  = 0;
  localparam int BIT_PEND = 3;

  typedef struct packed {
    logic [NDOM-1:0]   setDom;
    logic [NDOM-1:0]   clrDom;
    logic              maskOn;
    logic              maskOff;
    logic              statRd;
    logic              rdValid;
    logic [ADDR_W-1:0] rdSel;
  } dseq_strobe_t;
endpackage

// File: rtl/dseq_settle.sv
module dseq_settle #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic setCmd,
  input  logic clrCmd,
  output logic reqQ,
  output logic upQ
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      upQ  <= 1'b0;
      cntQ <= '0;
    end else if (clrCmd && reqQ) begin
      reqQ <= 1'b0;
      cntQ <= CNT_W'(SETTLE);
    end else if (setCmd && !reqQ) begin
      reqQ <= 1'b1;
      cntQ <= CNT_W'(SETTLE);
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
      if (cntQ == CNT_W'(1)) upQ <= reqQ;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(SETTLE));

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && !setCmd && !clrCmd) |=> $stable(upQ));

  p_rise_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upQ) |-> reqQ);

  p_fall_needs_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upQ) |-> !reqQ);
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NDOM-1:0]   domStable,
  input  logic [NDOM-1:0]   domAny,
  output dseq_strobe_t      strb
);
  logic [NDOM-1:0] upOk;
  logic [NDOM-1:0] dnOk;
  logic [NDOM-1:0] cmdEn;
  logic [NDOM-1:0] cmdDis;
  logic            unusedBits;

  assign unusedBits = ^regWdata[DATA_W-1:NDOM] ^ domStable[NDOM-1] ^ domAny[0];

  for (genvar k = 0; k < NDOM; k++) begin : g_ok
    if (k == 0) begin : g_first
      assign upOk[k] = 1'b1;
    end else begin : g_up
      assign upOk[k] = domStable[k-1];
    end
    if (k == NDOM - 1) begin : g_last
      assign dnOk[k] = 1'b1;
    end else begin : g_dn
      assign dnOk[k] = ~domAny[k+1];
    end
  end

  always_comb begin
    cmdEn  = (regWr && regAddr == A_EN)  ? regWdata[NDOM-1:0] : '0;
    cmdDis = (regWr && regAddr == A_DIS) ? regWdata[NDOM-1:0] : '0;
    strb.setDom  = cmdEn & upOk;
    strb.clrDom  = cmdDis & dnOk;
    strb.maskOn  = regWr && regAddr == A_IEN  && regWdata[BIT_SOF];
    strb.maskOff = regWr && regAddr == A_IDIS && regWdata[BIT_SOF];
    strb.statRd  = regRd && regAddr == A_STAT;
    strb.rdValid = regRd;
    strb.rdSel   = regAddr;
  end
endmodule

// File: rtl/dseq_dp.sv
module dseq_dp
  import dseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dseq_strobe_t      strb,
  input  logic              sofPulse,
  output logic [NDOM-1:0]   domReq,
  output logic [NDOM-1:0]   domUp,
  output logic [NDOM-1:0]   domStable,
  output logic [NDOM-1:0]   domAny,
  output logic              irqOut,
  output logic [DATA_W-1:0] regRdata
);
  logic              maskQ;
  logic              pendQ;
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    dseq_settle #(.SETTLE(SETTLE)) u_settle (
      .clk    (clk),
      .rstN   (rstN),
      .setCmd (strb.setDom[g]),
      .clrCmd (strb.clrDom[g]),
      .reqQ   (domReq[g]),
      .upQ    (domUp[g])
    );
  end

  assign domStable = domUp & domReq;
  assign domAny    = domUp | domReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (strb.maskOff)     maskQ <= 1'b0;
      else if (strb.maskOn) maskQ <= 1'b1;
      if (sofPulse)         pendQ <= 1'b1;
      else if (strb.statRd) pendQ <= 1'b0;
    end
  end

  assign irqOut = pendQ & maskQ;

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      A_STAT: begin
        rdNext[NDOM-1:0] = domUp;
        rdNext[BIT_PEND] = pendQ;
      end
      A_IMASK: rdNext[BIT_SOF] = maskQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regRdata <= '0;
    else if (strb.rdValid) regRdata <= rdNext;
  end

  for (genvar g = 1; g < NDOM; g++) begin : g_chk
    p_chain_r4: assert property (@(posedge clk) disable iff (!rstN)
      domUp[g] |-> domUp[g-1]);
  end

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statRd && !sofPulse) |=> !irqOut);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(sofPulse) || $past(strb.maskOn)));

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskOff |=> !irqOut);
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sofPulse,
  output logic              irqOut,
  output logic [2:0]        domainReq,
  output logic [2:0]        domainUp
);
  dseq_strobe_t    strb;
  logic [NDOM-1:0] domStable;
  logic [NDOM-1:0] domAny;

  dseq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .regWr     (regWr),
    .regRd     (regRd),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .domStable (domStable),
    .domAny    (domAny),
    .strb      (strb)
  );

  dseq_dp #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sofPulse  (sofPulse),
    .domReq    (domainReq),
    .domUp     (domainUp),
    .domStable (domStable),
    .domAny    (domAny),
    .irqOut    (irqOut),
    .regRdata  (regRdata)
  );
endmodule

// File: tb/disp_pwr_seq_bench.sv
module disp_pwr_seq_bench;
  localparam int DATA_W = 8;
  localparam int SETTLE = 4;
  localparam int NV     = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWr = 1'b0;
  logic              regRd = 1'b0;
  logic [2:0]        regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              sofPulse = 1'b0;
  logic              irqOut;
  logic [2:0]        domainReq;
  logic [2:0]        domainUp;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_pwr_seq #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_disp_pwr_seq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sofPulse(sofPulse),
    .irqOut(irqOut), .domainReq(domainReq), .domainUp(domainUp)
  );

  // vector: {op[1:0], addr[2:0], data[7:0], wait[7:0], expUp[2:0], expIrq, reqNo[7:0]}
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 3'd0, 8'h02, 8'd6, 3'b000, 1'b0, 8'd4},  // R4 sync without pixel clock
    {2'd1, 3'd0, 8'h00, 8'd6, 3'b000, 1'b0, 8'd2},  // R2 zero enable
    {2'd1, 3'd0, 8'h01, 8'd4, 3'b001, 1'b0, 8'd1},  // R1 pixel clock up
    {2'd1, 3'd0, 8'h04, 8'd6, 3'b001, 1'b0, 8'd4},  // R4 display without sync
    {2'd1, 3'd0, 8'h02, 8'd4, 3'b011, 1'b0, 8'd1},  // R1 sync up
    {2'd1, 3'd1, 8'h01, 8'd6, 3'b011, 1'b0, 8'd5},  // R5 pixel release under sync
    {2'd1, 3'd0, 8'h04, 8'd4, 3'b111, 1'b0, 8'd1},  // R1 display up
    {2'd1, 3'd1, 8'h00, 8'd6, 3'b111, 1'b0, 8'd2},  // R2 zero release
    {2'd1, 3'd1, 8'h02, 8'd6, 3'b111, 1'b0, 8'd5},  // R5 sync release under display
    {2'd1, 3'd1, 8'h04, 8'd4, 3'b011, 1'b0, 8'd5},  // R5 display down
    {2'd1, 3'd1, 8'h02, 8'd4, 3'b001, 1'b0, 8'd5},  // R5 sync down
    {2'd1, 3'd1, 8'h01, 8'd4, 3'b000, 1'b0, 8'd5},  // R5 pixel clock down
    {2'd1, 3'd0, 8'h07, 8'd6, 3'b001, 1'b0, 8'd4}   // R4 all at once: pixel only
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic sof();
    @(negedge clk);
    sofPulse = 1'b1;
    @(negedge clk);
    sofPulse = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    bit sawUp;
    repeat (3) @(negedge clk);
    chk("R10 up in reset", 32'(domainUp), 0);
    chk("R10 irq in reset", 32'(irqOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 req after reset", 32'(domainReq), 0);
    rdReg(3'd5, rd);
    chk("R10 mask after reset", 32'(rd), 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      if (v[32:31] == 2'd1) wrReg(v[30:28], v[27:20]);
      repeat (int'(v[19:12])) @(negedge clk);
      chk($sformatf("R%0d vector %0d up", v[7:0], i), 32'(domainUp), 32'(v[11:9]));
      chk($sformatf("R%0d vector %0d irq", v[7:0], i), 32'(irqOut), 32'(v[8]));
    end

    // R3 exact settling edge
    wrReg(3'd0, 8'h02);
    chk("R1 request visible", 32'(domainReq), 3);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R3 not before settle", 32'(domainUp), 1);
    @(negedge clk);
    chk("R3 at settle", 32'(domainUp), 3);

    // R6 release cancels settling enable
    wrReg(3'd0, 8'h04);
    wrReg(3'd1, 8'h04);
    chk("R6 request dropped", 32'(domainReq), 3);
    sawUp = 1'b0;
    for (int c = 0; c < SETTLE + 2; c++) begin
      @(negedge clk);
      if (domainUp[2]) sawUp = 1'b1;
    end
    chk("R6 display never up", 32'(sawUp), 0);

    // R4 enable refused while the lower stage is being released
    wrReg(3'd1, 8'h02);
    wrReg(3'd0, 8'h04);
    repeat (SETTLE + 2) @(negedge clk);
    chk("R4 pending release up", 32'(domainUp), 1);
    chk("R4 pending release req", 32'(domainReq), 1);

    // R7 / R8 / R9 interrupt path
    rdReg(3'd2, rd);
    chk("R7 status running bits", 32'(rd), 8'h01);
    sof();
    chk("R9 masked irq low", 32'(irqOut), 0);
    rdReg(3'd2, rd);
    chk("R7 pending shown", 32'(rd), 8'h09);
    rdReg(3'd2, rd);
    chk("R7 pending cleared by read", 32'(rd), 8'h01);
    wrReg(3'd3, 8'h00);
    rdReg(3'd5, rd);
    chk("R2 zero mask write", 32'(rd), 0);
    wrReg(3'd3, 8'h01);
    rdReg(3'd5, rd);
    chk("R8 mask set", 32'(rd), 1);
    chk("R9 no pending no irq", 32'(irqOut), 0);
    sof();
    chk("R9 irq raised", 32'(irqOut), 1);
    @(negedge clk);
    regRd = 1'b1; regAddr = 3'd2; sofPulse = 1'b1;
    @(negedge clk);
    regRd = 1'b0; sofPulse = 1'b0;
    chk("R7 set beats ack", 32'(irqOut), 1);
    rdReg(3'd2, rd);
    chk("R9 irq cleared by read", 32'(irqOut), 0);
    sof();
    wrReg(3'd4, 8'h01);
    chk("R8 mask clear drops irq", 32'(irqOut), 0);
    rdReg(3'd5, rd);
    chk("R8 mask reads clear", 32'(rd), 0);

    finishRun();
  end
endmodule